// File: doc/BRIEF.md
# Peripheral Byte Bus Strobe Sequencer

This block runs single-byte transfers on an asynchronous 8-bit slave bus that serves ordinary byte-wide peripherals. An internal requester hands over one request at a time. A request carries an address, a select index, a direction, write data and a flag that picks a DMA acknowledge line instead of a chip select. The sequencer drives the select and then the read or write strobe. It holds the select after the strobe and returns read data together with a one-cycle completion pulse.

Four timing registers set each phase in bus clocks: select-to-strobe lead, strobe width, select hold after the strobe, and a minimum quiet gap from the end of one strobe to the start of the next. A slow peripheral can pull the ready input low to stretch the strobe past its programmed width. The timing registers can be written only while no transfer is in flight. Each transfer copies them when it starts.

Top module: `pbus_seq`

## Requirements
- R1: During and right after reset, every chip select, DMA acknowledge and strobe is high (inactive), `bus_tc_o`, `bus_d_oe_o` and `done_o` are low, and `req_ready_o` is high.
- R2: A transfer with `req_dma_i`=0 drives only `bus_cs_no[req_sel_i]` low. With `req_dma_i`=1 it drives only `bus_dack_no[req_sel_i[1:0]]` low. No two select lines are ever low together.
- R3: The select goes low on the clock edge that accepts the request. The strobe starts S clocks later, where S is the latched setup count, with 0 meaning the same edge. The recovery rule in R7 can delay the strobe further.
- R4: When ready stays high, the strobe (`bus_rd_no` for reads, `bus_wr_no` for writes) is low for exactly max(W,1) clocks, where W is the latched width count. The two strobes are never low together.
- R5: Ready is sampled on each clock edge that closes a strobe cycle. The strobe ends on the first such edge where ready is high and at least max(W,1) strobe cycles have passed.
- R6: The select stays low for H clocks after the strobe ends, where H is the latched hold count. `done_o` is high for exactly one cycle: the first cycle with the select released.
- R7: The strobe start is no earlier than R clocks after the previous strobe ended, where R is the recovery count latched by the previous transfer. So the strobe starts at max(accept + S, previous end + R).
- R8: For a read, `rdata_o` takes the value of `bus_d_i` sampled on the edge that ends the strobe. It holds that value until the next read ends.
- R9: While the select is low, `bus_a_o` shows the request address. For a write, `bus_d_oe_o` is high and `bus_d_o` shows the write data. For a read, `bus_d_oe_o` is low.
- R10: `bus_tc_o` is high while the select is low for a DMA transfer that had `req_last_i` set, and low at all other times.
- R11: A timing write loads field `cfg_sel_i` (0 setup, 1 width, 2 hold, 3 recovery) only when `req_ready_o` is high. A write made while a transfer runs is ignored. A running transfer keeps the values it latched at its start.
- R12: A request is accepted on an edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from acceptance until the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_sel_i | input | 2 | Timing field select (0 setup, 1 width, 2 hold, 3 recovery) |
| cfg_data_i | input | CNT_W | Timing value in clocks |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_write_i | input | 1 | 1 write, 0 read |
| req_dma_i | input | 1 | Use a DMA acknowledge instead of a chip select |
| req_last_i | input | 1 | Final DMA transfer, raises terminal count |
| req_sel_i | input | SEL_W | Chip select or acknowledge index |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last read byte |
| bus_a_o | output | ADDR_W | Bus address |
| bus_d_o | output | DATA_W | Bus write data |
| bus_d_oe_o | output | 1 | Bus data drive enable |
| bus_d_i | input | DATA_W | Bus read data |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_cs_no | output | CS_N | Chip selects, active low |
| bus_dack_no | output | DMA_N | DMA acknowledges, active low |
| bus_tc_o | output | 1 | Terminal count |
| bus_rdy_i | input | 1 | Peripheral ready, low stretches the strobe |

## Verification
A phase counter left at the wrong value shows up as a strobe that starts, ends or releases its select on the wrong edge. The bench measures each of these edges in absolute cycle numbers within the same transfer. A stale recovery counter or a timing register that changes mid-transfer shows up in the next transfer's strobe start or strobe length, one transfer later at most. A wrong latched request field shows on the select, address, data or terminal-count pins in the first cycle of the transfer.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned CFG_FIELDS = 4;

  typedef enum logic [1:0] {
    CFG_SETUP = 2'd0,
    CFG_WIDTH = 2'd1,
    CFG_HOLD  = 2'd2,
    CFG_RECOV = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/pbus_timing_regs.sv
module pbus_timing_regs #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEF_SETUP = 1,
  parameter int unsigned DEF_WIDTH = 2,
  parameter int unsigned DEF_HOLD  = 1,
  parameter int unsigned DEF_RECOV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] setup_o,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] recov_o
);
  import pbus_pkg::*;

  localparam logic [CFG_FIELDS*CNT_W-1:0] DEF_PACK = {
    CNT_W'(DEF_RECOV), CNT_W'(DEF_HOLD), CNT_W'(DEF_WIDTH), CNT_W'(DEF_SETUP)
  };

  logic [CNT_W-1:0] field_q [CFG_FIELDS];

  for (genvar g = 0; g < CFG_FIELDS; g++) begin : g_field
    localparam logic [1:0] IDX = 2'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              field_q[g] <= DEF_PACK[g*CNT_W +: CNT_W];
      else if (we_i && idle_i && sel_i == IDX)  field_q[g] <= data_i;
    end

    AST_CFG_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !idle_i) |=> $stable(field_q[g])); // R11
  end

  assign setup_o = field_q[CFG_SETUP];
  assign width_o = field_q[CFG_WIDTH];
  assign hold_o  = field_q[CFG_HOLD];
  assign recov_o = field_q[CFG_RECOV];
endmodule

// File: rtl/pbus_phase_ctrl.sv
module pbus_phase_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] recov_i,
  input  logic             rdy_i,
  output pbus_pkg::phase_e phase_o,
  output logic             strobe_end_o,
  output logic             done_o
);
  import pbus_pkg::*;

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam int unsigned      LEN_W = CNT_W + 2;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rec_q, rec_d;
  logic [CNT_W-1:0] width_q, hold_q, recov_q;
  logic [CNT_W-1:0] width_eff;
  logic             done_q, done_d;
  logic             strobe_end;
  logic             rec_ok;

  // zero width still yields one strobe clock
  assign width_eff = (width_i == '0) ? ONE : width_i;
  assign rec_ok    = (rec_q <= ONE);

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    strobe_end = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (setup_i == '0 && rec_ok) begin
            phase_d = PH_STROBE;
            cnt_d   = width_eff;
          end else begin
            phase_d = PH_SETUP;
            cnt_d   = setup_i;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q <= ONE && rec_ok) begin
          phase_d = PH_STROBE;
          cnt_d   = width_q;
        end else if (cnt_q > ONE) begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_STROBE: begin
        if (cnt_q > ONE) begin
          cnt_d = cnt_q - ONE;
        end else if (rdy_i) begin
          strobe_end = 1'b1;
          if (hold_q == '0) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_HOLD;
            cnt_d   = hold_q;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q <= ONE) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // recovery timer runs across transfers
  always_comb begin
    if (strobe_end)        rec_d = recov_q;
    else if (rec_q != '0)  rec_d = rec_q - ONE;
    else                   rec_d = rec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      done_q  <= 1'b0;
      width_q <= ONE;
      hold_q  <= '0;
      recov_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rec_q   <= rec_d;
      done_q  <= done_d;
      if (start_i) begin
        width_q <= width_eff;
        hold_q  <= hold_i;
        recov_q <= recov_i;
      end
    end
  end

  assign phase_o      = phase_q;
  assign strobe_end_o = strobe_end;
  assign done_o       = done_q;

  // checker counters
  logic [LEN_W-1:0] len_q, gap_q;
  logic [CNT_W-1:0] prev_rec_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      gap_q      <= '1;
      prev_rec_q <= '0;
    end else begin
      if (phase_q == PH_STROBE) len_q <= (len_q == '1) ? len_q : len_q + 1'b1;
      else                      len_q <= '0;
      if (strobe_end) begin
        gap_q      <= '0;
        prev_rec_q <= recov_q;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_WIDTH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_end |-> (len_q + 1'b1 >= LEN_W'(width_q))); // R4
  AST_RECOV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_d == PH_STROBE && phase_q != PH_STROBE) |-> (gap_q + 1'b1 >= LEN_W'(prev_rec_q))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> phase_q == PH_IDLE); // R12
endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CS_N   = 8,
  parameter int unsigned DMA_N  = 4,
  localparam int unsigned SEL_W = $clog2(CS_N),
  localparam int unsigned DMA_W = $clog2(DMA_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  pbus_pkg::phase_e  phase_i,
  input  logic              strobe_end_i,
  input  logic              write_i,
  input  logic              dma_i,
  input  logic              last_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [ADDR_W-1:0] bus_a_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [CS_N-1:0]   bus_cs_no,
  output logic [DMA_N-1:0]  bus_dack_no,
  output logic              bus_tc_o,
  output logic [DATA_W-1:0] rdata_o
);
  import pbus_pkg::*;

  logic              write_q, dma_q, last_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              sel_act, strobe_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      dma_q   <= 1'b0;
      last_q  <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      write_q <= write_i;
      dma_q   <= dma_i;
      last_q  <= last_i;
      sel_q   <= sel_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rdata_q <= '0;
    else if (strobe_end_i && !write_q) rdata_q <= bus_d_i;
  end

  assign sel_act    = (phase_i != PH_IDLE);
  assign strobe_act = (phase_i == PH_STROBE);

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign bus_cs_no[g] = !(sel_act && !dma_q && sel_q == IDX);
  end

  for (genvar g = 0; g < DMA_N; g++) begin : g_dack
    localparam logic [DMA_W-1:0] IDX = DMA_W'(g);
    assign bus_dack_no[g] = !(sel_act && dma_q && sel_q[DMA_W-1:0] == IDX);
  end

  assign bus_rd_no  = !(strobe_act && !write_q);
  assign bus_wr_no  = !(strobe_act && write_q);
  assign bus_d_oe_o = sel_act && write_q;
  assign bus_d_o    = wdata_q;
  assign bus_a_o    = addr_q;
  assign bus_tc_o   = sel_act && dma_q && last_q;
  assign rdata_o    = rdata_q;

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~bus_cs_no, ~bus_dack_no})); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no)); // R4
  AST_STROBE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_no || !bus_wr_no) |-> ($countones({~bus_cs_no, ~bus_dack_no}) == 1)); // R3
  AST_PINS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_act && $past(sel_act)) |-> ($stable(bus_cs_no) && $stable(bus_dack_no)
      && $stable(bus_a_o) && $stable(bus_d_o) && $stable(bus_tc_o))); // R9
  AST_TC_DMA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_tc_o |-> (bus_dack_no != '1)); // R10
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CS_N      = 8,
  parameter int unsigned DMA_N     = 4,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEF_SETUP = 1,
  parameter int unsigned DEF_WIDTH = 2,
  parameter int unsigned DEF_HOLD  = 1,
  parameter int unsigned DEF_RECOV = 2,
  localparam int unsigned SEL_W    = $clog2(CS_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CNT_W-1:0]  cfg_data_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_dma_i,
  input  logic              req_last_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_a_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic              bus_rd_no,
  output logic              bus_wr_no,
  output logic [CS_N-1:0]   bus_cs_no,
  output logic [DMA_N-1:0]  bus_dack_no,
  output logic              bus_tc_o,
  input  logic              bus_rdy_i
);
  import pbus_pkg::*;

  phase_e           phase;
  logic             idle, start, strobe_end;
  logic [CNT_W-1:0] t_setup, t_width, t_hold, t_recov;

  assign idle        = (phase == PH_IDLE);
  assign start       = req_valid_i && idle;
  assign req_ready_o = idle;

  pbus_timing_regs #(
    .CNT_W(CNT_W), .DEF_SETUP(DEF_SETUP), .DEF_WIDTH(DEF_WIDTH),
    .DEF_HOLD(DEF_HOLD), .DEF_RECOV(DEF_RECOV)
  ) i_regs (
    .clk_i, .rst_ni,
    .idle_i (idle),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .setup_o(t_setup),
    .width_o(t_width),
    .hold_o (t_hold),
    .recov_o(t_recov)
  );

  pbus_phase_ctrl #(.CNT_W(CNT_W)) i_phase (
    .clk_i, .rst_ni,
    .start_i     (start),
    .setup_i     (t_setup),
    .width_i     (t_width),
    .hold_i      (t_hold),
    .recov_i     (t_recov),
    .rdy_i       (bus_rdy_i),
    .phase_o     (phase),
    .strobe_end_o(strobe_end),
    .done_o      (done_o)
  );

  pbus_pin_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N), .DMA_N(DMA_N)
  ) i_pins (
    .clk_i, .rst_ni,
    .start_i     (start),
    .phase_i     (phase),
    .strobe_end_i(strobe_end),
    .write_i     (req_write_i),
    .dma_i       (req_dma_i),
    .last_i      (req_last_i),
    .sel_i       (req_sel_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .bus_d_i     (bus_d_i),
    .bus_a_o     (bus_a_o),
    .bus_d_o     (bus_d_o),
    .bus_d_oe_o  (bus_d_oe_o),
    .bus_rd_no   (bus_rd_no),
    .bus_wr_no   (bus_wr_no),
    .bus_cs_no   (bus_cs_no),
    .bus_dack_no (bus_dack_no),
    .bus_tc_o    (bus_tc_o),
    .rdata_o     (rdata_o)
  );

  AST_READY_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !req_ready_o); // R12
endmodule

// File: tb/test_pbus_seq.sv
module test_pbus_seq;
  localparam int CLK_PERIOD = 30;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = '0;
  logic [3:0] cfg_data_i = '0;
  logic       req_valid_i = 1'b0, req_write_i = 1'b0, req_dma_i = 1'b0, req_last_i = 1'b0;
  logic [2:0] req_sel_i = '0;
  logic [7:0] req_addr_i = '0, req_wdata_i = '0, bus_d_i = '0;
  logic       bus_rdy_i = 1'b1;
  logic       req_ready_o, done_o, bus_d_oe_o, bus_rd_no, bus_wr_no, bus_tc_o;
  logic [7:0] rdata_o, bus_a_o, bus_d_o, bus_cs_no;
  logic [3:0] bus_dack_no;

  pbus_seq i_pbus_seq (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .req_valid_i, .req_ready_o, .req_write_i, .req_dma_i, .req_last_i,
    .req_sel_i, .req_addr_i, .req_wdata_i, .done_o, .rdata_o,
    .bus_a_o, .bus_d_o, .bus_d_oe_o, .bus_d_i, .bus_rd_no, .bus_wr_no,
    .bus_cs_no, .bus_dack_no, .bus_tc_o, .bus_rdy_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int m_s = 1, m_w = 2, m_h = 1, m_r = 2;
  int prev_end = -1000, prev_rec = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int fld, input int val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(fld); cfg_data_i = 4'(val);
    if (req_ready_o) begin
      case (fld)
        0: m_s = val;
        1: m_w = val;
        2: m_h = val;
        default: m_r = val;
      endcase
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic xfer(input bit wr, input bit dma, input int sel, input int addr,
                      input int wdata, input int rpat, input bit last,
                      input int stall, input bit busy_cfg);
    int e0, es, te, done_at, slen, sel_last, exp_es, weff, s, h, r;
    bit dec_ok, dat_ok, tc_ok, cont_ok, rdy_busy;
    bit strobe, any_sel;
    es = -1; te = -1; done_at = -1; slen = 0; sel_last = -1;
    dec_ok = 1; dat_ok = 1; tc_ok = 1; cont_ok = 1; rdy_busy = 1;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_dma_i = dma; req_last_i = last;
    req_sel_i = 3'(sel); req_addr_i = 8'(addr); req_wdata_i = 8'(wdata);
    s = m_s; h = m_h; r = m_r; weff = (m_w == 0) ? 1 : m_w;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    e0 = cyc;
    exp_es = (e0 + s > prev_end + prev_rec) ? e0 + s : prev_end + prev_rec;
    for (int k = 0; k < 300 && done_at < 0; k++) begin
      if (k > 0) @(negedge clk_i);
      if (busy_cfg && k == 1) begin
        cfg_we_i = 1'b1; cfg_sel_i = 2'd1; cfg_data_i = 4'd9;
      end else begin
        cfg_we_i = 1'b0;
      end
      if (!done_o && req_ready_o) rdy_busy = 0;
      strobe = wr ? !bus_wr_no : !bus_rd_no;
      if (wr ? !bus_rd_no : !bus_wr_no) dec_ok = 0;
      if (strobe) begin
        if (es < 0) es = cyc;
        slen++;
        bus_rdy_i = (slen >= weff + stall);
        bus_d_i = 8'(rpat);
      end else if (es >= 0 && te < 0) begin
        te = cyc;
        bus_rdy_i = 1'b1;
        bus_d_i = ~8'(rpat);
      end
      any_sel = (bus_cs_no != 8'hff) || (bus_dack_no != 4'hf);
      if (done_o) begin
        done_at = cyc;
        if (any_sel) cont_ok = 0;
      end else if (any_sel) begin
        sel_last = cyc;
        if (dma) begin
          if (bus_dack_no != ~(4'b1 << sel[1:0]) || bus_cs_no != 8'hff) dec_ok = 0;
        end else begin
          if (bus_cs_no != ~(8'b1 << sel) || bus_dack_no != 4'hf) dec_ok = 0;
        end
        if (bus_a_o != 8'(addr) || bus_d_oe_o != wr) dat_ok = 0;
        if (wr && bus_d_o != 8'(wdata)) dat_ok = 0;
        if (bus_tc_o != (dma && last)) tc_ok = 0;
      end else begin
        cont_ok = 0;
        if (bus_tc_o || bus_d_oe_o) tc_ok = 0;
      end
    end
    cfg_we_i = 1'b0;
    bus_rdy_i = 1'b1;
    if (exp_es > e0 + s) chk(es == exp_es, "R7 strobe start", es - e0, exp_es - e0);
    else                 chk(es == exp_es, "R3 strobe start", es - e0, exp_es - e0);
    if (stall > 0) chk(te - es == weff + stall, "R5 stretched width", te - es, weff + stall);
    else           chk(te - es == weff, "R4 strobe width", te - es, weff);
    chk(done_at == te + h && sel_last == done_at - 1 && cont_ok, "R6 hold/done",
        done_at - te, h);
    chk(dec_ok, "R2 select decode", int'(dec_ok), 1);
    chk(dat_ok, "R9 addr/data drive", int'(dat_ok), 1);
    chk(tc_ok, "R10 terminal count", int'(tc_ok), 1);
    chk(rdy_busy, "R12 ready low while busy", int'(rdy_busy), 1);
    if (!wr) chk(rdata_o == 8'(rpat), "R8 read data", int'(rdata_o), rpat & 255);
    prev_end = te; prev_rec = r;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    // R1 reset state
    chk(bus_cs_no == 8'hff && bus_dack_no == 4'hf && bus_rd_no && bus_wr_no,
        "R1 selects/strobes idle", int'({bus_cs_no, bus_dack_no}), 'hfff);
    chk(!done_o && !bus_tc_o && !bus_d_oe_o && req_ready_o, "R1 status idle",
        int'({done_o, bus_tc_o, bus_d_oe_o, req_ready_o}), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bus_cs_no == 8'hff && req_ready_o && bus_rd_no && bus_wr_no, "R1 after release",
        int'(bus_cs_no), 'hff);

    // defaults, read then write
    xfer(0, 0, 3, 'h12, 0, 'hA5, 0, 0, 0);
    xfer(1, 0, 7, 'h34, 'h5C, 0, 0, 0, 0);
    // all-zero timing: width 0 behaves as 1
    cfg_write(0, 0); cfg_write(1, 0); cfg_write(2, 0); cfg_write(3, 0);
    xfer(0, 0, 0, 'h01, 0, 'h3C, 0, 0, 0);
    xfer(1, 1, 2, 'h02, 'hC3, 0, 1, 0, 0);
    // long phases with ready stretch
    cfg_write(0, 5); cfg_write(1, 4); cfg_write(2, 3);
    xfer(0, 0, 5, 'hF0, 0, 'h96, 0, 3, 0);
    // recovery dominates back-to-back
    cfg_write(0, 0); cfg_write(1, 1); cfg_write(2, 0); cfg_write(3, 12);
    xfer(1, 0, 1, 'h10, 'h11, 0, 0, 0, 0);
    xfer(0, 1, 3, 'h20, 0, 'h69, 1, 0, 0);
    xfer(0, 1, 1, 'h21, 0, 'h70, 0, 2, 0);
    // R11: write while busy is ignored, later idle write takes effect
    cfg_write(1, 3); cfg_write(3, 0);
    xfer(1, 0, 4, 'h44, 'h88, 0, 0, 0, 1);
    xfer(0, 0, 4, 'h45, 0, 'h77, 0, 0, 0);
    chk(m_w == 3, "R11 busy write ignored", m_w, 3);
    cfg_write(1, 6);
    xfer(0, 0, 6, 'h46, 0, 'h5A, 0, 0, 0);

    for (int n = 0; n < 60; n++) begin
      if ($urandom % 2 == 0) begin
        cfg_write(0, $urandom % 5);
        cfg_write(1, $urandom % 6);
        cfg_write(2, $urandom % 4);
        cfg_write(3, $urandom % 13);
      end
      xfer(1'($urandom), 1'($urandom), $urandom % 8, $urandom % 256, $urandom % 256,
           $urandom % 256, 1'($urandom), ($urandom % 3 == 0) ? $urandom % 4 : 0, 0);
    end
    finish_run();
  end
endmodule